// File: doc/BRIEF.md
# Debounced 4x4 Key Matrix Scanner with Capture Buffer

This block watches a 4x4 switch matrix, with four column drives and four row inputs that sit high through pull-ups. While it waits it drives every column low, so a press on any key pulls its row low. A low row, seen through a two-flop synchronizer, starts a scan. The scan drives one column low at a time and looks for a row that has gone low. When it finds one, the key code is the raw port byte: the row nibble in the upper four bits and the column nibble in the lower four. That byte is written to the next slot of a small external buffer.

After a key is stored the block ignores the matrix until the rows have stayed idle for a programmable, continuous release period. Capture stops once the ENTER code has been stored or the last buffer slot has been written. A `done` flag and a reason flag report this state. A one-cycle `rearm` pulse moves the write pointer back to the buffer base and turns capture on again.

Buffer writes travel on a valid/ready stream. While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold steady, and one key gives exactly one transfer. Back-pressure only delays that transfer. The matrix is not rescanned during the wait. `rearm` is the single exception to the holding rule: it takes priority, drops a pending transfer and withdraws `wr_valid`.

Top module: `kpad_scan_top`

## Requirements
- R1: After reset, `col_n` is 4'b0000, `wr_valid` is 0, and `done` and `done_by_enter` are both 0.
- R2: While waiting, all columns are driven low. A row that goes low starts a scan. During the scan exactly one column is low: column 0 first (`col_n`=1110), then 1101, 1011, 0111, and then back to 1110. The scan keeps cycling until a row is found low. A brief row glitch therefore writes nothing.
- R3: The stored code is {row nibble, column nibble}. Bits 7:4 hold the synchronized `row_n`, bits 3:0 hold `col_n`, and a 0 bit is active. Row r with column c gives {~(1<<r), ~(1<<c)}, for example row 1, column 2 gives 8'hDB.
- R4: Codes go to successive addresses BUF_BASE, BUF_BASE+1, and so on, counted from reset or the last re-arm. BUF_BASE defaults to 8'h50.
- R5: `wr_valid` stays high with a stable `wr_addr` and `wr_data` until `wr_ready` is seen. Each key press produces exactly one transfer.
- R6: After a transfer, no new key is accepted until the rows have been idle (all four 1) for SETTLE_CYCLES consecutive cycles. Any low row restarts that count.
- R7: Storing ENTER_CODE (default 8'h77, row 3 with column 3) sets `done`=1 and `done_by_enter`=1. After that there are no more writes, and `col_n` is 4'b1111 while done.
- R8: Writing the last slot (BUF_BASE+BUF_LEN-1) with a code other than ENTER sets `done`=1 and `done_by_enter`=0. After that there are no more writes.
- R9: `rearm` clears both done flags, resets the next address to BUF_BASE and drops any pending transfer. A full release period must then pass before the next key is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_n | input | 4 | Row lines, pulled high, low when a pressed key meets a low column |
| rearm | input | 1 | One-cycle pulse: restart capture at the buffer base |
| col_n | output | 4 | Column drives, low is active |
| wr_valid | output | 1 | Buffer write request |
| wr_ready | input | 1 | Buffer accepts the write this cycle |
| wr_addr | output | 8 | Buffer address of the write |
| wr_data | output | 8 | Key code {rows, columns} |
| done | output | 1 | Capture has stopped |
| done_by_enter | output | 1 | Capture stopped on the ENTER code rather than on a full buffer |

## Verification
The hardest state to reach is a pending transfer that is still held under back-pressure when `rearm` arrives. To get there, the bench holds `wr_ready` low through a press and waits for `wr_valid`. It then pulses `rearm` and checks that the request is withdrawn and that the next key is stored at the base address again. The bounce cases are also hard to reach. One is a row glitch that starts a scan that never finds a key. The other is a press that is released and touched again inside the release window. The bench's matrix model produces both, and it checks the column walk and the absence of any transfer.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  localparam int LINES  = 4;
  localparam int CODE_W = 2 * LINES;
  localparam int DWELL  = 4;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_SCAN  = 3'd1,
    ST_PUSH  = 3'd2,
    ST_QUIET = 3'd3,
    ST_STOP  = 3'd4
  } kp_state_t;
endpackage

// File: rtl/kpad_sync.sv
module kpad_sync #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '1;
    else        chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '1;
      else        chain[s] <= chain[s-1];
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/kpad_quiet_timer.sv
module kpad_quiet_timer #(
  parameter int SETTLE_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic idle,
  output logic expired
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || !idle)    cnt <= '0;
    else if (cnt != LAST)      cnt <= cnt + 1'b1;
  end

  assign expired = run && idle && (cnt == LAST);
endmodule

// File: rtl/kpad_buf_ptr.sv
module kpad_buf_ptr
  import kpad_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUF_BASE = 'h50,
  parameter int BUF_LEN = 16,
  parameter logic [CODE_W-1:0] ENTER_CODE = 8'h77
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rearm,
  input  logic              fire,
  input  logic [CODE_W-1:0] code,
  output logic [ADDR_W-1:0] addr,
  output logic              stop_now,
  output logic              done,
  output logic              done_by_enter
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BUF_BASE);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BUF_BASE + BUF_LEN - 1);

  logic is_enter;
  assign is_enter = (code == ENTER_CODE);
  assign stop_now = is_enter || (addr == LAST_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr          <= BASE_A;
      done          <= 1'b0;
      done_by_enter <= 1'b0;
    end else if (rearm) begin
      addr          <= BASE_A;
      done          <= 1'b0;
      done_by_enter <= 1'b0;
    end else if (fire) begin
      if (stop_now) begin
        done          <= 1'b1;
        done_by_enter <= is_enter;
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end

  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (addr >= BASE_A && addr <= LAST_A));
  assert_enter_implies_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_by_enter |-> done);
  assert_no_fire_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fire);
endmodule

// File: rtl/kpad_scanner.sv
module kpad_scanner
  import kpad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  rows_s,
  input  logic              rearm,
  input  logic              quiet_done,
  input  logic              stop_now,
  input  logic              wr_ready,
  output logic [LINES-1:0]  col_n,
  output logic              wr_valid,
  output logic [CODE_W-1:0] code,
  output logic              quiet_run,
  output logic              fire
);
  localparam int IW = $clog2(LINES);
  localparam int DW = $clog2(DWELL);
  localparam logic [DW-1:0] DLAST = DW'(DWELL - 1);

  kp_state_t      st;
  logic [IW-1:0]  col_idx;
  logic [DW-1:0]  dwell;
  logic           rows_idle;

  assign rows_idle = &rows_s;

  always_comb begin
    unique case (st)
      ST_SCAN: col_n = ~(LINES'(1) << col_idx);
      ST_STOP: col_n = '1;
      default: col_n = '0;
    endcase
  end

  assign wr_valid  = (st == ST_PUSH);
  assign fire      = wr_valid && wr_ready && !rearm;
  assign quiet_run = (st == ST_QUIET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_WAIT;
      col_idx <= '0;
      dwell   <= '0;
      code    <= '0;
    end else if (rearm) begin
      st <= ST_QUIET;
    end else begin
      unique case (st)
        ST_WAIT: begin
          if (!rows_idle) begin
            st      <= ST_SCAN;
            col_idx <= '0;
            dwell   <= '0;
          end
        end
        ST_SCAN: begin
          if (dwell == DLAST) begin
            dwell <= '0;
            if (!rows_idle) begin
              code <= {rows_s, col_n};
              st   <= ST_PUSH;
            end else begin
              col_idx <= col_idx + 1'b1;
            end
          end else begin
            dwell <= dwell + 1'b1;
          end
        end
        ST_PUSH: begin
          if (wr_ready) st <= stop_now ? ST_STOP : ST_QUIET;
        end
        ST_QUIET: begin
          if (quiet_done) st <= ST_WAIT;
        end
        default: st <= ST_STOP;
      endcase
    end
  end

  assert_one_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN) |-> ($countones(col_n) == LINES - 1));
  assert_hold_until_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !rearm) |=> (wr_valid && $stable(code)));
  assert_quiet_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_QUIET && !rows_idle && !rearm) |=> (st == ST_QUIET));
  assert_rearm_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !wr_valid);
endmodule

// File: rtl/kpad_scan_top.sv
module kpad_scan_top
  import kpad_pkg::*;
#(
  parameter int SETTLE_CYCLES = 5_000_000,
  parameter int BUF_BASE = 'h50,
  parameter int BUF_LEN = 16,
  parameter logic [7:0] ENTER_CODE = 8'h77
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] row_n,
  input  logic       rearm,
  output logic [3:0] col_n,
  output logic       wr_valid,
  input  logic       wr_ready,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       done,
  output logic       done_by_enter
);
  logic [LINES-1:0] rows_s;
  logic quiet_run, quiet_done, stop_now, fire;

  kpad_sync #(.W(LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(row_n), .d_sync(rows_s)
  );

  kpad_quiet_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_quiet (
    .clk(clk), .rst_n(rst_n), .run(quiet_run), .idle(&rows_s), .expired(quiet_done)
  );

  kpad_scanner u_scan (
    .clk(clk), .rst_n(rst_n), .rows_s(rows_s), .rearm(rearm),
    .quiet_done(quiet_done), .stop_now(stop_now), .wr_ready(wr_ready),
    .col_n(col_n), .wr_valid(wr_valid), .code(wr_data),
    .quiet_run(quiet_run), .fire(fire)
  );

  kpad_buf_ptr #(
    .ADDR_W(8), .BUF_BASE(BUF_BASE), .BUF_LEN(BUF_LEN), .ENTER_CODE(ENTER_CODE)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .fire(fire), .code(wr_data),
    .addr(wr_addr), .stop_now(stop_now), .done(done), .done_by_enter(done_by_enter)
  );

  assert_silent_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rearm) |=> !wr_valid);
  assert_stopped_cols_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !rearm) |-> (col_n == 4'b1111));
endmodule

// File: tb/kpad_scan_top_bench.sv
module kpad_scan_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 20;
  localparam int LEN = 5;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] row_n;
  logic rearm = 1'b0;
  logic [3:0] col_n;
  logic wr_valid;
  logic wr_ready = 1'b1;
  logic [7:0] wr_addr, wr_data;
  logic done, done_by_enter;

  int checks = 0;
  int fails = 0;
  int nwr = 0;
  int cycles = 0;
  int exp_ptr = 0;
  logic [15:0] expq[$];

  logic pressed = 1'b0;
  int pr = 0, pc = 0;
  logic [3:0] glitch = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  kpad_scan_top #(.SETTLE_CYCLES(SETTLE), .BUF_BASE('h50), .BUF_LEN(LEN),
                  .ENTER_CODE(8'h77)) u_kpad_scan_top (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .rearm(rearm), .col_n(col_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .done_by_enter(done_by_enter)
  );

  always_comb begin
    for (int i = 0; i < 4; i++)
      row_n[i] = !(glitch[i] || (pressed && pr == i && col_n[pc] == 1'b0));
  end

  function automatic logic [7:0] key_code(int r, int c);
    return {~(4'b0001 << r), ~(4'b0001 << c)};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready && !rearm) begin
      nwr++;
      if (expq.size() == 0) begin
        check(0, "R5 unexpected write", {wr_addr, wr_data}, 0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        check({wr_addr, wr_data} == e, "R3/R4 write addr,data", {wr_addr, wr_data}, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      check(0, "watchdog", cycles, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic expect_key(int r, int c);
    expq.push_back({8'(8'h50 + exp_ptr), key_code(r, c)});
    exp_ptr++;
  endtask

  task automatic wait_write(int start, string tag);
    for (int t = 0; t < 400 && nwr == start; t++) tick();
    check(nwr == start + 1, tag, nwr, start + 1);
  endtask

  task automatic release_settle();
    pressed = 1'b0;
    tick(SETTLE + 15);
  endtask

  task automatic press_key(int r, int c, bit want, string tag);
    int start;
    start = nwr;
    if (want) expect_key(r, c);
    pr = r; pc = c; pressed = 1'b1;
    if (want) wait_write(start, tag);
    else tick(3 * SETTLE);
    tick(10);
    check(nwr == start + (want ? 1 : 0), tag, nwr, start + (want ? 1 : 0));
    release_settle();
  endtask

  task automatic wait_col_change(logic [3:0] prev, logic [3:0] want, string tag);
    for (int t = 0; t < 50 && col_n == prev; t++) tick();
    check(col_n == want, tag, col_n, want);
  endtask

  initial begin
    int start;
    logic [7:0] held;
    tick(3);
    // R1 reset state
    check(col_n == 4'b0000, "R1 col_n", col_n, 0);
    check(!wr_valid, "R1 wr_valid", wr_valid, 0);
    check(!done && !done_by_enter, "R1 done flags", {done, done_by_enter}, 0);
    rst_n = 1'b1;
    tick(5);

    // R2: glitch starts a scan, column walk, no write
    start = nwr;
    glitch = 4'b0001;
    tick(3);
    glitch = 4'b0000;
    wait_col_change(4'b0000, 4'b1110, "R2 first column");
    wait_col_change(4'b1110, 4'b1101, "R2 second column");
    wait_col_change(4'b1101, 4'b1011, "R2 third column");
    wait_col_change(4'b1011, 4'b0111, "R2 fourth column");
    wait_col_change(4'b0111, 4'b1110, "R2 wrap to column 0");
    check(nwr == start && !wr_valid, "R2 glitch gives no write", nwr, start);

    // R3 R4: key found by the ongoing scan
    press_key(0, 0, 1'b1, "R3 key 0,0 at base");

    // R6: bounce inside release window is ignored
    start = nwr;
    expect_key(1, 1);
    pr = 1; pc = 1; pressed = 1'b1;
    wait_write(start, "R4 key 1,1");
    for (int k = 0; k < 3; k++) begin
      pressed = 1'b0; tick(5);
      pressed = 1'b1; tick(8);
    end
    pressed = 1'b0; tick(5);
    pressed = 1'b1; tick(2 * SETTLE);
    check(nwr == start + 1, "R6 bounce ignored", nwr, start + 1);
    release_settle();
    press_key(2, 3, 1'b1, "R6 key after release period");

    // R7: ENTER stops capture
    press_key(3, 3, 1'b1, "R7 enter key stored");
    check(done && done_by_enter, "R7 done by enter", {done, done_by_enter}, 3);
    check(col_n == 4'b1111, "R7 columns high while done", col_n, 4'hF);
    press_key(2, 1, 1'b0, "R7 no write after enter");

    // R9 rearm, R5 back-pressure
    rearm = 1'b1; tick(); rearm = 1'b0;
    exp_ptr = 0;
    check(!done && !done_by_enter, "R9 flags cleared", {done, done_by_enter}, 0);
    tick(SETTLE + 10);
    wr_ready = 1'b0;
    start = nwr;
    expect_key(1, 2);
    pr = 1; pc = 2; pressed = 1'b1;
    for (int t = 0; t < 400 && !wr_valid; t++) tick();
    held = wr_data;
    check(wr_valid && wr_addr == 8'h50, "R9 rearm restarts at base", wr_addr, 8'h50);
    tick(12);
    check(wr_valid && wr_data == held && wr_data == 8'hDB, "R5 held under back-pressure",
          wr_data, 8'hDB);
    wr_ready = 1'b1;
    wait_write(start, "R5 single transfer");
    tick(10);
    check(nwr == start + 1, "R5 exactly one transfer", nwr, start + 1);
    release_settle();

    // R8: fill buffer
    press_key(2, 1, 1'b1, "R8 key 2,1");
    press_key(0, 3, 1'b1, "R8 key 0,3");
    press_key(3, 0, 1'b1, "R8 key 3,0");
    press_key(0, 1, 1'b1, "R8 last slot");
    check(done && !done_by_enter, "R8 done by full", {done, done_by_enter}, 2);
    press_key(1, 3, 1'b0, "R8 no write when full");

    // R9: rearm aborts pending write
    rearm = 1'b1; tick(); rearm = 1'b0;
    exp_ptr = 0;
    tick(SETTLE + 10);
    wr_ready = 1'b0;
    pr = 2; pc = 2; pressed = 1'b1;
    for (int t = 0; t < 400 && !wr_valid; t++) tick();
    check(wr_valid, "R9 pending write present", wr_valid, 1);
    rearm = 1'b1; tick(); rearm = 1'b0;
    check(!wr_valid, "R9 rearm drops pending write", wr_valid, 0);
    wr_ready = 1'b1;
    release_settle();
    press_key(2, 2, 1'b1, "R9 next key at base after abort");
    check(expq.size() == 0, "R4 all expected writes seen", expq.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule